// File: doc/BRIEF.md
# Converter Conversion and Autoshutdown Sequencer

This block sits on the host side of a two-channel simultaneous-sampling converter. The converter is controlled through one active-low conversion-start line, reports progress on a BUSY input, and delivers its two results over a serial port that is gated by chip select. The sequencer turns a single-cycle start request into a full cycle. It drives the start line low, waits for BUSY to rise and fall, shifts both results in at the same time, and then presents them with a one-cycle valid strobe.

A low-power flag travels with each request and selects what happens to the converter after the conversion. With the flag clear, the sequencer raises the start line while BUSY is still high, so the converter stays powered. With the flag set, the line is still low when BUSY falls, so the converter drops into shutdown. The results are then read while the line stays low.

A later request first wakes the converter with a rising edge. The line is then held high for the power-up time, counted in clock cycles from `CLK_HZ`, before the next falling edge. The same hold applies after reset. Requests that arrive during a cycle are kept and served afterwards.

Top module: `adc_cnv_seq`

## Requirements
- R1: During and after reset the conversion-start line is high, chip select is high, the serial clock is low and the valid strobe is low. The first falling edge of the start line comes no earlier than HOLD cycles after reset is released.
- R2: A start request while idle drives the start line low. The line never falls while BUSY is high.
- R3: With the low-power flag clear (0) at the request, the start line is raised after BUSY is seen high and is high when BUSY falls. It stays high afterwards, and a following request pulls it low again within three cycles with no hold.
- R4: With the low-power flag set (1) at the request, the start line is low when BUSY falls and stays low after the readout until the next request.
- R5: A request in shutdown first raises the start line and holds it high for exactly HOLD+1 clock cycles, then pulls it low.
- R6: After BUSY falls, chip select goes low for exactly DATA_W serial-clock rising edges. Both data inputs are sampled on each rising edge, most significant bit first. Chip select is never low while BUSY is high, and the serial clock only toggles while chip select is low.
- R7: After the readout, result_valid_o pulses high for exactly one cycle with both assembled words on the result outputs. The words hold until the next readout.
- R8: In low-power mode the readout takes place with the start line low, so the results come from the shut-down converter.
- R9: A start request that arrives during power-up, a conversion or a readout is kept and served once the sequencer returns to idle or shutdown. The low-power flag given with it is used.
- R10: HOLD equals ceil(70e-6 × CLK_HZ) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req_i | input | 1 | Single-cycle conversion request |
| low_power_i | input | 1 | Shutdown-after-conversion flag, sampled with the request |
| busy_i | input | 1 | BUSY from the converter, high while converting |
| cnv_n_o | output | 1 | Active-low conversion-start and wake line |
| cs_n_o | output | 1 | Active-low serial chip select |
| sclk_o | output | 1 | Generated serial clock |
| sdata_a_i | input | 1 | Serial data, channel A |
| sdata_b_i | input | 1 | Serial data, channel B |
| result_a_o | output | DATA_W | Channel A result |
| result_b_o | output | DATA_W | Channel B result |
| result_valid_o | output | 1 | One-cycle strobe for fresh results |

## Verification
The hardest state to reach is a wake from shutdown with a request already waiting. It needs a low-power conversion to finish with the start line low. A second request must then land during that conversion, so that it is served straight out of shutdown and must pass through the full timed hold. The bench gets there by issuing a low-power request, waiting for the modelled BUSY to rise, and then issuing a normal-mode request. The converter model logs the start-line level at every BUSY fall and the high time before every falling edge, so the sleep decision and the hold length can be checked at the ports.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_PWRUP,
        SEQ_IDLE,
        SEQ_CNV,
        SEQ_BUSY,
        SEQ_READ,
        SEQ_SLEEP,
        SEQ_WAKE
    } seq_state_e;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_LOW,
        RD_HIGH
    } rd_state_e;

    // power-up hold of 70 us in clock cycles, rounded up
    function automatic int unsigned hold_cycles(input longint unsigned clk_hz);
        longint unsigned c;
        c = (clk_hz * 70 + 64'd999_999) / 64'd1_000_000;
        return int'(c);
    endfunction

endpackage

// File: rtl/hold_timer.sv
module hold_timer #(
    parameter int unsigned HOLD = 14000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic done_o
);
    localparam int unsigned CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LIMIT = CW'(HOLD);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i)
            cnt_d = '0;
        else if (cnt_q != LIMIT)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == LIMIT);

    // R5: the count never passes the limit and a restart clears done next cycle
    assert_timer_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !done_o);

endmodule

// File: rtl/dual_shift_rx.sv
module dual_shift_rx
    import adc_seq_pkg::*;
#(
    parameter int unsigned W    = 14,
    parameter int unsigned DIV  = 2,
    parameter int unsigned NCH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [NCH-1:0]   sdata_i,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             done_o,
    output logic [NCH*W-1:0] words_o
);
    localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int unsigned BW = $clog2(W);
    localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(W - 1);

    typedef struct packed {
        rd_state_e             state;
        logic                  cs_n;
        logic                  sclk;
        logic                  done;
        logic [DW-1:0]         div;
        logic [BW-1:0]         bits;
        logic [NCH-1:0][W-1:0] sh;
    } rx_t;

    rx_t q, d;

    always_comb begin
        d = q;
        d.done = 1'b0;
        unique case (q.state)
            RD_IDLE: begin
                if (go_i) begin
                    d.state = RD_LOW;
                    d.cs_n  = 1'b0;
                    d.sclk  = 1'b0;
                    d.div   = '0;
                    d.bits  = '0;
                end
            end
            RD_LOW: begin
                if (q.div == DIV_LAST) begin
                    d.sclk  = 1'b1;
                    d.div   = '0;
                    d.state = RD_HIGH;
                    for (int c = 0; c < int'(NCH); c++)
                        d.sh[c] = {q.sh[c][W-2:0], sdata_i[c]};
                end else begin
                    d.div = q.div + 1'b1;
                end
            end
            RD_HIGH: begin
                if (q.div == DIV_LAST) begin
                    d.sclk = 1'b0;
                    d.div  = '0;
                    if (q.bits == BIT_LAST) begin
                        d.cs_n  = 1'b1;
                        d.done  = 1'b1;
                        d.state = RD_IDLE;
                    end else begin
                        d.bits  = q.bits + 1'b1;
                        d.state = RD_LOW;
                    end
                end else begin
                    d.div = q.div + 1'b1;
                end
            end
            default: d.state = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= RD_IDLE;
            q.cs_n  <= 1'b1;
            q.sclk  <= 1'b0;
            q.done  <= 1'b0;
            q.div   <= '0;
            q.bits  <= '0;
            q.sh    <= '0;
        end else begin
            q <= d;
        end
    end

    assign cs_n_o = q.cs_n;
    assign sclk_o = q.sclk;
    assign done_o = q.done;

    for (genvar c = 0; c < int'(NCH); c++) begin : g_ch
        assign words_o[c*W +: W] = q.sh[c];
    end

    // R6: serial clock only runs inside a chip-select window
    assert_sclk_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);
    // R6: the window closes together with the done strobe
    assert_done_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cs_n_o && $past(!cs_n_o)));

endmodule

// File: rtl/adc_cnv_seq.sv
module adc_cnv_seq
    import adc_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 200_000_000,
    parameter int unsigned DATA_W   = 14,
    parameter int unsigned SCLK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req_i,
    input  logic              low_power_i,
    input  logic              busy_i,
    output logic              cnv_n_o,
    output logic              cs_n_o,
    output logic              sclk_o,
    input  logic              sdata_a_i,
    input  logic              sdata_b_i,
    output logic [DATA_W-1:0] result_a_o,
    output logic [DATA_W-1:0] result_b_o,
    output logic              result_valid_o
);
    localparam int unsigned HOLD_CYC = hold_cycles(longint'(CLK_HZ));
    localparam int unsigned NCH      = 2;
    localparam int unsigned HCW      = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        seq_state_e        state;
        logic              cnv_n;
        logic              lp;
        logic              pend;
        logic              pend_lp;
        logic [DATA_W-1:0] res_a;
        logic [DATA_W-1:0] res_b;
        logic              valid;
    } seq_t;

    seq_t q, d;

    logic                    tmr_restart, tmr_done;
    logic                    rd_go, rd_done;
    logic [NCH*DATA_W-1:0]   rd_words;
    logic                    accepting, take, take_lp;

    hold_timer #(.HOLD(HOLD_CYC)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (tmr_restart),
        .done_o    (tmr_done)
    );

    dual_shift_rx #(.W(DATA_W), .DIV(SCLK_DIV), .NCH(NCH)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (rd_go),
        .sdata_i ({sdata_b_i, sdata_a_i}),
        .cs_n_o  (cs_n_o),
        .sclk_o  (sclk_o),
        .done_o  (rd_done),
        .words_o (rd_words)
    );

    always_comb begin
        d           = q;
        d.valid     = 1'b0;
        rd_go       = 1'b0;
        tmr_restart = 1'b0;
        accepting   = ((q.state == SEQ_IDLE) && !busy_i) || (q.state == SEQ_SLEEP);
        take        = start_req_i || q.pend;
        take_lp     = start_req_i ? low_power_i : q.pend_lp;

        if (start_req_i && !accepting) begin
            d.pend    = 1'b1;
            d.pend_lp = low_power_i;
        end

        unique case (q.state)
            SEQ_PWRUP: begin
                d.cnv_n = 1'b1;
                if (tmr_done) d.state = SEQ_IDLE;
            end
            SEQ_IDLE: begin
                if (take && !busy_i) begin
                    d.state = SEQ_CNV;
                    d.cnv_n = 1'b0;
                    d.lp    = take_lp;
                    d.pend  = 1'b0;
                end
            end
            SEQ_CNV: begin
                if (busy_i) begin
                    d.state = SEQ_BUSY;
                    if (!q.lp) d.cnv_n = 1'b1;
                end
            end
            SEQ_BUSY: begin
                if (!busy_i) begin
                    d.state = SEQ_READ;
                    rd_go   = 1'b1;
                end
            end
            SEQ_READ: begin
                if (rd_done) begin
                    d.res_a = rd_words[0 +: DATA_W];
                    d.res_b = rd_words[DATA_W +: DATA_W];
                    d.valid = 1'b1;
                    d.state = q.lp ? SEQ_SLEEP : SEQ_IDLE;
                end
            end
            SEQ_SLEEP: begin
                if (take) begin
                    d.state     = SEQ_WAKE;
                    d.cnv_n     = 1'b1;
                    d.lp        = take_lp;
                    d.pend      = 1'b0;
                    tmr_restart = 1'b1;
                end
            end
            SEQ_WAKE: begin
                if (tmr_done) begin
                    d.state = SEQ_CNV;
                    d.cnv_n = 1'b0;
                end
            end
            default: d.state = SEQ_PWRUP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state   <= SEQ_PWRUP;
            q.cnv_n   <= 1'b1;
            q.lp      <= 1'b0;
            q.pend    <= 1'b0;
            q.pend_lp <= 1'b0;
            q.res_a   <= '0;
            q.res_b   <= '0;
            q.valid   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cnv_n_o        = q.cnv_n;
    assign result_a_o     = q.res_a;
    assign result_b_o     = q.res_b;
    assign result_valid_o = q.valid;

    // ---- checking logic: high-time of the start line and wake obligation
    logic [HCW-1:0] chk_high_q;
    logic           chk_need_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_high_q <= '0;
            chk_need_q <= 1'b1;
        end else begin
            if (!cnv_n_o)
                chk_high_q <= '0;
            else if (chk_high_q != HCW'(HOLD_CYC))
                chk_high_q <= chk_high_q + 1'b1;
            if (q.state == SEQ_SLEEP)
                chk_need_q <= 1'b1;
            else if (!cnv_n_o)
                chk_need_q <= 1'b0;
        end
    end

    // R5 / R1: after reset or a wake the start line was high for the full hold
    assert_wake_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cnv_n_o) && chk_need_q) |-> (chk_high_q == HCW'(HOLD_CYC)));
    // R2: no start edge while the converter is busy
    assert_no_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnv_n_o) |-> !busy_i);
    // R3: normal mode keeps the line high across the end of conversion
    assert_stay_powered_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_i) && !q.lp) |-> (cnv_n_o && $past(cnv_n_o)));
    // R4: low-power mode leaves the line low across the end of conversion
    assert_enter_sleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_i) && q.lp) |-> (!cnv_n_o && $past(!cnv_n_o)));
    // R6: never read while converting
    assert_no_read_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> cs_n_o);
    // R7: strobe lasts a single cycle
    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |=> !result_valid_o);
    // R7: results stay put between strobes
    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid_o |-> ($stable(result_a_o) && $stable(result_b_o)));

endmodule

// File: tb/adc_cnv_seq_tb.sv
`timescale 1ns/1ps
module adc_cnv_seq_tb;
    localparam int unsigned CLK_HZ   = 1_050_000;
    localparam int unsigned W        = 14;
    localparam int unsigned DIV      = 2;
    localparam int          HOLD     = 74;   // ceil(70e-6 * 1.05e6) = ceil(73.5)
    localparam int          BUSY_DLY = 2;
    localparam int          BUSY_LEN = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0, low_power = 1'b0;
    logic busy_r = 1'b0, sda = 1'b0, sdb = 1'b0;
    logic cnv_n_o, cs_n_o, sclk_o, result_valid_o;
    logic [W-1:0] result_a_o, result_b_o;

    always #2.5 clk = ~clk;

    adc_cnv_seq #(.CLK_HZ(CLK_HZ), .DATA_W(W), .SCLK_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_req_i(start_req), .low_power_i(low_power),
        .busy_i(busy_r), .cnv_n_o(cnv_n_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
        .sdata_a_i(sda), .sdata_b_i(sdb), .result_a_o(result_a_o),
        .result_b_o(result_b_o), .result_valid_o(result_valid_o)
    );

    int checks = 0, errors = 0;
    bit done_flag = 0;

    // ---- converter model and port monitors (negedge)
    logic [W-1:0] pat_a = '0, pat_b = '0, sh_a = '0, sh_b = '0;
    logic cnv_prev = 1, cs_prev = 1, sclk_prev = 0, valid_prev = 0;
    int hi_cnt = 0, last_hi = 0, fall_cnt = 0, busy_cnt = 0;
    int rises = 0, last_rises = 0, valid_cnt = 0;
    int start_busy_viol = 0, cs_busy_viol = 0, width_viol = 0, sclk_viol = 0;
    logic cnv_at_bfall = 1, cnv_at_cs = 1;
    logic [W-1:0] got_a = '0, got_b = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            hi_cnt = 0; busy_cnt = 0; busy_r = 0;
        end else begin
            if (cnv_n_o) hi_cnt++;
            if (cnv_prev && !cnv_n_o) begin
                fall_cnt++; last_hi = hi_cnt;
                if (busy_r) start_busy_viol++;
                busy_cnt = BUSY_DLY + BUSY_LEN;
            end
            if (!cnv_n_o) hi_cnt = 0;
            if (busy_cnt > 0) begin
                busy_cnt--;
                if (busy_r && busy_cnt == 0) cnv_at_bfall = cnv_n_o;
                busy_r = (busy_cnt > 0 && busy_cnt <= BUSY_LEN);
            end
            if (!cs_n_o && busy_r) cs_busy_viol++;
            if (cs_n_o && sclk_o) sclk_viol++;
            if (cs_prev && !cs_n_o) begin
                sh_a = pat_a; sh_b = pat_b; rises = 0; cnv_at_cs = cnv_n_o;
            end
            if (!cs_n_o && !sclk_prev && sclk_o) rises++;
            if (!cs_n_o && sclk_prev && !sclk_o) begin
                sh_a = {sh_a[W-2:0], 1'b0}; sh_b = {sh_b[W-2:0], 1'b0};
            end
            if (!cs_prev && cs_n_o) last_rises = rises;
            sda = sh_a[W-1]; sdb = sh_b[W-1];
            if (result_valid_o) begin
                valid_cnt++; got_a = result_a_o; got_b = result_b_o;
                if (valid_prev) width_viol++;
            end
        end
        cnv_prev = cnv_n_o; cs_prev = cs_n_o; sclk_prev = sclk_o; valid_prev = result_valid_o;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic request(input logic lp);
        @(negedge clk); start_req = 1'b1; low_power = lp;
        @(negedge clk); start_req = 1'b0; low_power = 1'b0;
    endtask

    task automatic wait_valid(input int target);
        for (int i = 0; i < 3000 && valid_cnt < target; i++) @(negedge clk);
        chk(valid_cnt >= target, "R7 valid strobe seen", valid_cnt, target);
    endtask

    task automatic check_words(input string req, input logic [W-1:0] ea, input logic [W-1:0] eb);
        chk(got_a == ea, req, int'(got_a), int'(ea));
        chk(got_b == eb, req, int'(got_b), int'(eb));
        chk(last_rises == W, "R6 sclk rising edges per read", last_rises, W);
    endtask

    task automatic t_reset_and_first();
        repeat (4) @(negedge clk);
        chk(cnv_n_o == 1 && cs_n_o == 1, "R1 reset lines high", {cnv_n_o, cs_n_o}, 3);
        chk(sclk_o == 0 && result_valid_o == 0, "R1 reset sclk/valid low", {sclk_o, result_valid_o}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        pat_a = 14'h3FFF; pat_b = 14'h0000;
        request(1'b0);   // R9: arrives during power-up, kept pending
        wait_valid(1);
        chk(last_hi >= HOLD && last_hi <= HOLD + 4, "R1 R10 first hold window", last_hi, HOLD);
        check_words("R6 R9 first words", 14'h3FFF, 14'h0000);
    endtask

    task automatic t_normal(input logic [W-1:0] a, input logic [W-1:0] b);
        int v0 = valid_cnt;
        pat_a = a; pat_b = b;
        request(1'b0);
        wait_valid(v0 + 1);
        check_words("R6 R7 normal words", a, b);
        chk(cnv_at_bfall == 1, "R3 line high at busy fall", cnv_at_bfall, 1);
        repeat (6) @(negedge clk);
        chk(cnv_n_o == 1, "R3 stays powered", cnv_n_o, 1);
        chk(result_a_o == a, "R7 result holds", int'(result_a_o), int'(a));
    endtask

    task automatic t_back_to_back();
        int f0 = fall_cnt, n = 0;
        pat_a = 14'h2AAA; pat_b = 14'h1555;
        @(negedge clk); start_req = 1'b1; low_power = 1'b0;
        @(negedge clk); start_req = 1'b0; n = 1;
        while (fall_cnt == f0 && n < 50) begin @(negedge clk); n++; end
        chk(n <= 3, "R2 R3 start without hold", n, 3);
        wait_valid(valid_cnt + 1);
        check_words("R6 alternating words", 14'h2AAA, 14'h1555);
    endtask

    task automatic t_shutdown();
        int v0 = valid_cnt;
        pat_a = 14'h0001; pat_b = 14'h2000;
        request(1'b1);
        wait_valid(v0 + 1);
        chk(cnv_at_bfall == 0, "R4 line low at busy fall", cnv_at_bfall, 0);
        chk(cnv_at_cs == 0, "R8 read with line low", cnv_at_cs, 0);
        check_words("R8 words from shutdown", 14'h0001, 14'h2000);
        repeat (30) @(negedge clk);
        chk(cnv_n_o == 0, "R4 stays in shutdown", cnv_n_o, 0);
    endtask

    task automatic t_wake();
        int v0 = valid_cnt;
        pat_a = 14'h1234; pat_b = 14'h0F0F;
        request(1'b0);
        wait_valid(v0 + 1);
        chk(last_hi == HOLD + 1, "R5 R10 wake hold length", last_hi, HOLD + 1);
        check_words("R5 words after wake", 14'h1234, 14'h0F0F);
    endtask

    task automatic t_pending_from_sleep();
        int v0 = valid_cnt, f0 = fall_cnt;
        pat_a = 14'h3C3C; pat_b = 14'h03C3;
        request(1'b1);
        for (int i = 0; i < 50 && !busy_r; i++) @(negedge clk);
        request(1'b0);   // R9: queued while converting, with flag clear
        wait_valid(v0 + 2);
        chk(fall_cnt == f0 + 2, "R9 two conversions", fall_cnt, f0 + 2);
        chk(last_hi == HOLD + 1, "R9 R5 pending wake holds", last_hi, HOLD + 1);
        chk(cnv_at_bfall == 1, "R9 pending used its flag", cnv_at_bfall, 1);
        check_words("R9 pending words", 14'h3C3C, 14'h03C3);
    endtask

    task automatic report();
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        t_reset_and_first();
        t_normal(14'h3FFF, 14'h3FFF);
        t_normal(14'h0000, 14'h3FFF);
        t_back_to_back();
        t_shutdown();
        t_wake();
        t_pending_from_sleep();
        chk(start_busy_viol == 0, "R2 no start while busy", start_busy_viol, 0);
        chk(cs_busy_viol == 0, "R6 no read while busy", cs_busy_viol, 0);
        chk(sclk_viol == 0, "R6 sclk gated by cs", sclk_viol, 0);
        chk(width_viol == 0, "R7 one-cycle strobe", width_viol, 0);
        report();
    end

    initial begin
        #(5 * 150_000);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

endmodule